// File: doc/BRIEF.md
# Word Clock Band Detector

This block watches an external word clock and decides whether its rate can be followed by one of two local crystal oscillator families. The word clock is brought into the reference clock domain. Its rising edges are found, and the block counts reference cycles across a fixed number of word clock periods. The count is compared against ten narrow windows, one for each supported sample rate. Because the gate length is a fixed number of word clock periods, a fast input is classified sooner than a slow one.

When a window matches and the previous measurement gave the same answer, the block raises its lock-enable output. It also reports the band index and which oscillator family to pull: the 24.576 MHz one for multiples of 48 kHz, or the 22.5792 MHz one for multiples of 44.1 kHz. When nothing matches, lock-enable is low and the converter keeps running on its native oscillator. If the word clock disappears, a timeout drops the lock and measurement starts again on the next edge.

Top module: `wclk_band_detect`

## Requirements
- R1: While reset is asserted and after its release, until a result is committed, `lock_en` is 0, `band_idx` is 15 (the no-match code) and `fam_48k` is 1.
- R2: A steady word clock at a nominal rate is reported with this band index: 16 kHz=0, 22.05 kHz=1, 24 kHz=2, 32 kHz=3, 44.1 kHz=4, 48 kHz=5, 88.2 kHz=6, 96 kHz=7, 176.4 kHz=8, 192 kHz=9. `lock_en` is 1 in each case.
- R3: `fam_48k` is 1 for bands 0, 2, 3, 5, 7 and 9, and for the no-match code. It is 0 for bands 1, 4, 6 and 8.
- R4: A band matches only when the measured count lies between the nominal count scaled by (1 - PPM/10^6), rounded down, minus SLACK, and the nominal count scaled by (1 + PPM/10^6), rounded up, plus SLACK. A rate outside every window gives `lock_en`=0 and `band_idx`=15. The nominal count is REF_HZ*GATE_EDGES/rate.
- R5: A measurement spans GATE_EDGES word clock periods, from one rising edge to the GATE_EDGES-th rising edge after it. The next measurement begins at that closing edge. A committed result appears on the outputs at most 6 reference cycles after its closing edge. With the default parameters this gives 32 ms at 16 kHz.
- R6: The outputs take a new result only when two consecutive measurements give the same band or both give no match. After a fresh start, the outputs change no earlier than the closing edge of the second measurement.
- R7: Between commits, the outputs hold their values while the next measurement runs.
- R8: If no rising edge arrives for TIMEOUT = 2*REF_HZ/16000 reference cycles during a measurement, the outputs go to the no-match state within a few cycles. They do not change earlier than that.
- R9: After a timeout, measurement restarts at the next rising edge. A steady input then locks at the closing edge of the second measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Local reference clock that is counted |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wclk_in | input | 1 | External word clock, asynchronous to clk_ref |
| lock_en | output | 1 | 1 when the oscillator should be locked to the word clock |
| band_idx | output | 4 | Matched band index 0..9, or 15 for no match |
| fam_48k | output | 1 | 1 selects the 24.576 MHz family, 0 selects the 22.5792 MHz family |

## Verification
A word clock rising edge reaches the edge pulse after two synchronizer cycles. The measurement result is registered one cycle later, and the outputs take it one cycle after that, about four reference cycles in all. The bench drives each closing edge itself and samples on a falling edge six cycles later. It also samples just before the closing edge of the second measurement, where the outputs must still show the old state. The timeout is checked on both sides: well before TIMEOUT cycles have passed since the last edge, the lock must still hold, and a few hundred cycles past it, the no-match state must be showing.

// File: rtl/wcbd_pkg.sv
`timescale 1ns/1ps
package wcbd_pkg;

  localparam int NUM_BANDS = 10;
  localparam int IDX_W     = 4;
  localparam logic [IDX_W-1:0] NO_BAND = 4'hF;
  localparam longint unsigned SLOWEST_HZ = 64'd16000;
  localparam longint unsigned MILLION    = 64'd1000000;

  // Nominal sample rate of each band in Hz; order fixes the reported index.
  function automatic longint unsigned band_rate_hz(input int idx);
    case (idx)
      0:       return 64'd16000;
      1:       return 64'd22050;
      2:       return 64'd24000;
      3:       return 64'd32000;
      4:       return 64'd44100;
      5:       return 64'd48000;
      6:       return 64'd88200;
      7:       return 64'd96000;
      8:       return 64'd176400;
      default: return 64'd192000;
    endcase
  endfunction

  // 1 when the band is a multiple of 8 kHz (24.576 MHz oscillator family).
  function automatic logic band_is_48k(input int idx);
    case (idx)
      1, 4, 6, 8: return 1'b0;
      default:    return 1'b1;
    endcase
  endfunction

  // Lowest accepted reference count for a band.
  function automatic longint unsigned band_lo(
    input longint unsigned ref_hz, input longint unsigned gate,
    input longint unsigned ppm,    input longint unsigned slack,
    input int idx);
    longint unsigned num, den, q;
    num = ref_hz * gate * (MILLION - ppm);
    den = band_rate_hz(idx) * MILLION;
    q   = num / den;
    return (q > slack) ? (q - slack) : 64'd0;
  endfunction

  // Highest accepted reference count for a band.
  function automatic longint unsigned band_hi(
    input longint unsigned ref_hz, input longint unsigned gate,
    input longint unsigned ppm,    input longint unsigned slack,
    input int idx);
    longint unsigned num, den;
    num = ref_hz * gate * (MILLION + ppm);
    den = band_rate_hz(idx) * MILLION;
    return (num + den - 64'd1) / den + slack;
  endfunction

endpackage

// File: rtl/wcbd_sync_edge.sv
`timescale 1ns/1ps
module wcbd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  // STAGES synchronizer flops plus one history flop for the edge compare.
  logic [STAGES:0] shift_q;
  logic [STAGES:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

  // R5: a rising edge is reported as a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/wcbd_period_meter.sv
`timescale 1ns/1ps
module wcbd_period_meter #(
  parameter int GATE_EDGES  = 512,
  parameter int TIMEOUT_CYC = 3072,
  parameter int CNT_W       = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] val_o,
  output logic             timeout_o
);

  localparam int EDGE_W = $clog2(GATE_EDGES + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(GATE_EDGES - 1);
  localparam logic [TO_W-1:0]   IDLE_LIM  = TO_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

  typedef enum logic {M_WAIT, M_RUN} meter_state_t;

  meter_state_t      st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [EDGE_W-1:0] edges_q, edges_d;
  logic [TO_W-1:0]   idle_q, idle_d;
  logic              done_d, to_d;
  logic [CNT_W-1:0]  val_d;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    edges_d = edges_q;
    idle_d  = idle_q;
    val_d   = val_o;
    done_d  = 1'b0;
    to_d    = 1'b0;
    case (st_q)
      M_WAIT: begin
        idle_d = '0;
        if (rise_i) begin
          st_d    = M_RUN;
          cnt_d   = '0;
          edges_d = '0;
        end
      end
      default: begin
        cnt_d = cnt_inc;
        if (rise_i) begin
          idle_d = '0;
          if (edges_q == LAST_EDGE) begin
            done_d  = 1'b1;
            val_d   = cnt_inc;
            cnt_d   = '0;
            edges_d = '0;
          end else begin
            edges_d = edges_q + 1'b1;
          end
        end else if (idle_q == IDLE_LIM) begin
          to_d = 1'b1;
          st_d = M_WAIT;
        end else begin
          idle_d = idle_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= M_WAIT;
      cnt_q     <= '0;
      edges_q   <= '0;
      idle_q    <= '0;
      val_o     <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      edges_q   <= edges_d;
      idle_q    <= idle_d;
      val_o     <= val_d;
      done_o    <= done_d;
      timeout_o <= to_d;
    end
  end

  // R5: a measurement closes only on a word clock edge
  a_r5_done_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rise_i));

  // R8: a timeout is never raised in a cycle that saw an edge
  a_r8_timeout_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !$past(rise_i));

  // R8: completion and timeout are exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

endmodule

// File: rtl/wcbd_band_match.sv
`timescale 1ns/1ps
module wcbd_band_match
  import wcbd_pkg::*;
#(
  parameter int REF_HZ     = 24576000,
  parameter int GATE_EDGES = 512,
  parameter int PPM        = 100,
  parameter int SLACK      = 1,
  parameter int CNT_W      = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] val_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             fam_o
);

  logic [NUM_BANDS-1:0] hit_v;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam longint unsigned LO = band_lo(longint'(REF_HZ), longint'(GATE_EDGES),
                                             longint'(PPM), longint'(SLACK), b);
    localparam longint unsigned HI = band_hi(longint'(REF_HZ), longint'(GATE_EDGES),
                                             longint'(PPM), longint'(SLACK), b);
    logic [63:0] val_wide;
    assign val_wide  = 64'(val_i);
    assign hit_v[b]  = (val_wide >= LO) && (val_wide <= HI);
  end

  always_comb begin
    idx_o = NO_BAND;
    fam_o = 1'b1;
    for (int b = NUM_BANDS - 1; b >= 0; b--) begin
      if (hit_v[b]) begin
        idx_o = IDX_W'(b);
        fam_o = band_is_48k(b);
      end
    end
    hit_o = |hit_v;
  end

  // R2: at most one window can claim a measurement
  a_r2_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v));

endmodule

// File: rtl/wcbd_result_reg.sv
`timescale 1ns/1ps
module wcbd_result_reg
  import wcbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             timeout_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fam_i,
  output logic             lock_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             fam_o
);

  logic [IDX_W-1:0] prev_q, prev_d;
  logic             prev_vld_q, prev_vld_d;
  logic             lock_d, fam_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    prev_d     = prev_q;
    prev_vld_d = prev_vld_q;
    lock_d     = lock_o;
    idx_d      = idx_o;
    fam_d      = fam_o;
    if (timeout_i) begin
      lock_d     = 1'b0;
      idx_d      = NO_BAND;
      fam_d      = 1'b1;
      prev_vld_d = 1'b0;
    end else if (done_i) begin
      if (prev_vld_q && (prev_q == idx_i)) begin
        lock_d = hit_i;
        idx_d  = idx_i;
        fam_d  = fam_i;
      end
      prev_d     = idx_i;
      prev_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= NO_BAND;
      prev_vld_q <= 1'b0;
      lock_o     <= 1'b0;
      idx_o      <= NO_BAND;
      fam_o      <= 1'b1;
    end else begin
      prev_q     <= prev_d;
      prev_vld_q <= prev_vld_d;
      lock_o     <= lock_d;
      idx_o      <= idx_d;
      fam_o      <= fam_d;
    end
  end

  // R7: outputs move only on a completed measurement or a timeout
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_i || timeout_i) |=> $stable({lock_o, idx_o, fam_o}));

  // R8: a timeout leaves the no-match state behind it
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_i |=> (!lock_o && idx_o == NO_BAND && fam_o));

  // R6: lock rises only on a completion that follows an earlier result
  a_r6_two_agree: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(done_i) && $past(prev_vld_q)));

  // R3: family select agrees with the reported band while locked
  a_r3_family: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (fam_o == band_is_48k(int'(idx_o))));

  // R2: a locked index is always a real band
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (int'(idx_o) < NUM_BANDS));

endmodule

// File: rtl/wclk_band_detect.sv
`timescale 1ns/1ps
module wclk_band_detect
  import wcbd_pkg::*;
#(
  parameter int REF_HZ      = 24576000,
  parameter int GATE_EDGES  = 512,
  parameter int PPM         = 100,
  parameter int SLACK       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       wclk_in,
  output logic       lock_en,
  output logic [3:0] band_idx,
  output logic       fam_48k
);

  localparam int TIMEOUT_CYC = int'(64'd2 * longint'(REF_HZ) / SLOWEST_HZ);
  localparam int CNT_W       = $clog2(GATE_EDGES * TIMEOUT_CYC + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             rise;
  logic             done;
  logic             timeout;
  logic [CNT_W-1:0] meas_val;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             hit_fam;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wcbd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n_int),
    .async_in (wclk_in),
    .rise_o   (rise)
  );

  wcbd_period_meter #(
    .GATE_EDGES  (GATE_EDGES),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
  ) u_meter (
    .clk       (clk_ref),
    .rst_n     (rst_n_int),
    .rise_i    (rise),
    .done_o    (done),
    .val_o     (meas_val),
    .timeout_o (timeout)
  );

  wcbd_band_match #(
    .REF_HZ     (REF_HZ),
    .GATE_EDGES (GATE_EDGES),
    .PPM        (PPM),
    .SLACK      (SLACK),
    .CNT_W      (CNT_W)
  ) u_match (
    .clk   (clk_ref),
    .rst_n (rst_n_int),
    .val_i (meas_val),
    .hit_o (hit),
    .idx_o (hit_idx),
    .fam_o (hit_fam)
  );

  wcbd_result_reg u_result (
    .clk       (clk_ref),
    .rst_n     (rst_n_int),
    .done_i    (done),
    .timeout_i (timeout),
    .hit_i     (hit),
    .idx_i     (hit_idx),
    .fam_i     (hit_fam),
    .lock_o    (lock_en),
    .idx_o     (band_idx),
    .fam_o     (fam_48k)
  );

endmodule

// File: tb/wclk_band_detect_bench.sv
`timescale 1ns/1ps
module wclk_band_detect_bench;

  localparam int CLK_PERIOD = 40;
  localparam int REF_HZ     = 25000000;
  localparam int GATE       = 4;
  localparam int TIMEOUT    = 2 * REF_HZ / 16000;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       wclk_in;
  logic       lock_en;
  logic [3:0] band_idx;
  logic       fam_48k;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

  wclk_band_detect #(
    .REF_HZ     (REF_HZ),
    .GATE_EDGES (GATE),
    .PPM        (100),
    .SLACK      (1),
    .SYNC_STAGES(2)
  ) u_wclk_band_detect (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .wclk_in  (wclk_in),
    .lock_en  (lock_en),
    .band_idx (band_idx),
    .fam_48k  (fam_48k)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input int lk, input int idx, input int fam);
    @(negedge clk_ref);
    check(req, "lock_en", int'(lock_en), lk);
    check(req, "band_idx", int'(band_idx), idx);
    check(req, "fam_48k", int'(fam_48k), fam);
  endtask

  task automatic run_wclk(input real hz, input int nrise);
    real half;
    half = 1.0e9 / (2.0 * hz);
    for (int i = 0; i < nrise; i++) begin
      wclk_in = 1'b1;
      #(half);
      wclk_in = 1'b0;
      #(half);
    end
  endtask

  task automatic go_quiet();
    wclk_in = 1'b0;
    repeat (TIMEOUT + 40) @(posedge clk_ref);
  endtask

  // Fresh start, two measurements, then the closing edge of the second one.
  task automatic t_lock_band(input string req, input real hz, input int idx, input int fam);
    real half;
    half = 1.0e9 / (2.0 * hz);
    go_quiet();
    run_wclk(hz, 2 * GATE);
    expect_out({req, " R6 before second close"}, 0, 15, 1);
    wclk_in = 1'b1;
    repeat (6) @(posedge clk_ref);
    expect_out({req, " R5 R9 after second close"}, 1, idx, fam);
    #(half - 7.0 * CLK_PERIOD);
    wclk_in = 1'b0;
    #(half);
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    wclk_in = 1'b0;
    repeat (3) @(posedge clk_ref);
    expect_out("R1 in reset", 0, 15, 1);
    rst_n = 1'b1;
    repeat (5) @(posedge clk_ref);
    expect_out("R1 after release", 0, 15, 1);
  endtask

  task automatic t_all_bands();
    t_lock_band("R2 R3 48k",    48000.0,  5, 1);
    t_lock_band("R2 R3 44.1k",  44100.0,  4, 0);
    t_lock_band("R2 R3 192k",   192000.0, 9, 1);
    t_lock_band("R2 R3 176.4k", 176400.0, 8, 0);
    t_lock_band("R2 R3 96k",    96000.0,  7, 1);
    t_lock_band("R2 R3 88.2k",  88200.0,  6, 0);
    t_lock_band("R2 R3 32k",    32000.0,  3, 1);
    t_lock_band("R2 R3 24k",    24000.0,  2, 1);
    t_lock_band("R2 R3 22.05k", 22050.0,  1, 0);
    t_lock_band("R2 R3 R5 16k", 16000.0,  0, 1);
  endtask

  task automatic t_window();
    // R4: 50 ppm high stays inside the 48 kHz window
    t_lock_band("R4 inside", 48000.0 * 1.00005, 5, 1);
    // R4: 2000 ppm high is outside every window from a fresh start
    go_quiet();
    run_wclk(48000.0 * 1.002, 3 * GATE + 1);
    expect_out("R4 outside fresh", 0, 15, 1);
  endtask

  task automatic t_hold_and_switch();
    t_lock_band("R7 setup", 44100.0, 4, 0);
    run_wclk(44100.0, GATE + 1);
    expect_out("R7 hold during next measurements", 1, 4, 0);
    t_lock_band("R6 setup", 48000.0, 5, 1);
    run_wclk(48000.0 * 1.002, 3 * GATE + 1);
    expect_out("R4 R6 drift out of window", 0, 15, 1);
  endtask

  task automatic t_timeout();
    t_lock_band("R8 setup", 96000.0, 7, 1);
    repeat (TIMEOUT - 400) @(posedge clk_ref);
    expect_out("R8 no early drop", 1, 7, 1);
    repeat (600) @(posedge clk_ref);
    expect_out("R8 dropped after timeout", 0, 15, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_ref);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_all_bands();
    t_window();
    t_hold_and_switch();
    t_timeout();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule